// File: doc/BRIEF.md
# Flash Row Erase Controller

This block erases a single row of flash program memory when the CPU asks for it. Software selects the row with a 22-bit table pointer and sets the fields of a small control register. It unlocks the block by writing two key bytes in order to a key register, and then sets a start bit. The block latches the row index and raises a request on a request/acknowledge port toward the flash array. It then holds a CPU stall output high until an internal programming timer has counted out the long write.

Guards stop a stray erase. The control fields must select program memory rather than configuration space, writes must be enabled, and the erase operation must be selected. The unlock is used up by the next control write, so every erase needs a new key sequence. A start with writes disabled sets a sticky error flag and does not erase.

Top module: `flash_row_eraser`

## Requirements
- R1: After reset `ctrlView` is 0x00, and `cpuStall` and `eraseReq` are low.
- R2: A control write (`busSel`=0) stores data bits [3:0], which read back on `ctrlView`: bit0 selects program memory when 1, bit1 selects configuration space, bit2 enables writes, bit3 selects erase. `ctrlView` bit4 reads the start/busy state and bit5 reads the error flag; bits 7:6 read 0.
- R3: Key writes (`busSel`=1) of 0x55 and then 0xAA arm the block. A following control write with bit4=1, bit0=1, bit1=0, bit2=1 and bit3=1 then starts an erase, and `cpuStall` is high from the next cycle.
- R4: A control write with bit4=1 on an unarmed block starts nothing: `cpuStall` stays low and bit4 reads 0.
- R5: A key write whose value is not the next one expected, or a control write between the two key writes, returns the unlock tracker to idle.
- R6: Any control write disarms the block, so a second start with no new key sequence does nothing.
- R7: `cpuStall` and `ctrlView` bit4 stay high for exactly ERASE_CYCLES cycles after an accepted start, then clear by themselves.
- R8: `eraseReq` rises together with `cpuStall` and falls on `eraseAck` or when the timer ends. `eraseRow` holds the index latched at start for the whole erase, even if `tablePtr` changes.
- R9: `eraseRow` equals `tablePtr[21:6]` at start. Bits [5:0] have no effect.
- R10: A start with bit2=0 sets the error flag (bit5) one cycle later and does not erase. Writing 1 to bit5 clears the flag, and writing 0 leaves it set.
- R11: Bus writes made while `cpuStall` is high are ignored.
- R12: A start with bit0=0, bit1=1 or bit3=0 (and bit2=1) starts nothing and sets no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Bus write strobe, one cycle per write |
| busSel | input | 1 | 0 selects the control register, 1 selects the key register |
| busData | input | 8 | Write data |
| tablePtr | input | 22 | Table pointer byte address |
| ctrlView | output | 8 | Control register readback |
| cpuStall | output | 1 | High while the erase runs |
| eraseReq | output | 1 | Row erase request to the flash array |
| eraseRow | output | 16 | Row index sent with the request |
| eraseAck | input | 1 | Acknowledge from the flash array |

## Verification
Every bus write takes effect at the clock edge where it is sampled, so `ctrlView`, `cpuStall`, `eraseReq` and `eraseRow` all change one cycle after the write. The stall then lasts ERASE_CYCLES cycles, and an acknowledge clears `eraseReq` one cycle after it is sampled. A behavioural model in the bench advances on the same edge and is compared with the outputs on the falling edge of every cycle. Directed checks are sampled at that same point: one falling edge after the final write of each sequence, and the stall length is counted over falling edges.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  typedef enum logic [1:0] {KeyIdle, KeyGot55, KeyArmed} keyState_e;

  typedef struct packed {
    logic ctrlWr;
    logic errSet;
    logic eraseGo;
    logic eraseDone;
  } eraseStrobe_t;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  localparam int BIT_MEM   = 0;
  localparam int BIT_CFG   = 1;
  localparam int BIT_WREN  = 2;
  localparam int BIT_ERASE = 3;
  localparam int BIT_START = 4;
  localparam int BIT_ERR   = 5;
endpackage

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import flash_erase_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int ERASE_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busSel,
  input  logic [DATA_W-1:0] busData,
  input  logic              eraseAck,
  output eraseStrobe_t      strobe,
  output logic              busy,
  output logic              eraseReq
);
  localparam int TW = $clog2(ERASE_CYCLES + 1);
  localparam logic [TW-1:0] LAST = TW'(ERASE_CYCLES - 1);

  keyState_e keyState, keyNext;
  logic [TW-1:0] timer;
  logic keyWr, ctrlWr, startReq, fieldsOk;

  assign keyWr    = busWr && busSel && !busy;
  assign ctrlWr   = busWr && !busSel && !busy;
  assign startReq = ctrlWr && busData[BIT_START];
  assign fieldsOk = busData[BIT_MEM] && !busData[BIT_CFG] && busData[BIT_ERASE];

  always_comb begin
    strobe.ctrlWr    = ctrlWr;
    strobe.errSet    = startReq && !busData[BIT_WREN];
    strobe.eraseGo   = startReq && busData[BIT_WREN] && fieldsOk && (keyState == KeyArmed);
    strobe.eraseDone = busy && (timer == LAST);
  end

  always_comb begin
    keyNext = keyState;
    if (keyWr) begin
      if (keyState == KeyIdle && busData == KEY_FIRST)        keyNext = KeyGot55;
      else if (keyState == KeyGot55 && busData == KEY_SECOND) keyNext = KeyArmed;
      else                                                    keyNext = KeyIdle;
    end else if (ctrlWr) begin
      keyNext = KeyIdle;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyState <= KeyIdle;
      busy     <= 1'b0;
      timer    <= '0;
      eraseReq <= 1'b0;
    end else begin
      keyState <= keyNext;
      if (strobe.eraseGo) begin
        busy     <= 1'b1;
        timer    <= '0;
        eraseReq <= 1'b1;
      end else if (busy) begin
        if (strobe.eraseDone) begin
          busy  <= 1'b0;
          timer <= '0;
        end else begin
          timer <= timer + 1'b1;
        end
        if (eraseAck || strobe.eraseDone) eraseReq <= 1'b0;
      end
    end
  end

  assert_armed_before_go_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(keyState == KeyArmed));
  assert_key_consumed_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> keyState == KeyIdle);
  assert_timer_bounded_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> timer < TW'(ERASE_CYCLES));
  assert_req_inside_stall_R8: assert property (@(posedge clk) disable iff (!rstN)
    eraseReq |-> busy);
  assert_err_or_go_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.errSet, strobe.eraseGo}));
  assert_key_frozen_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(keyState));
endmodule

// File: rtl/flash_erase_dp.sv
module flash_erase_dp
  import flash_erase_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 22,
  parameter int OFS_W  = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  eraseStrobe_t           strobe,
  input  logic [DATA_W-1:0]      busData,
  input  logic [PTR_W-1:0]       tablePtr,
  input  logic                   busy,
  output logic [DATA_W-1:0]      ctrlView,
  output logic [PTR_W-OFS_W-1:0] eraseRow
);
  logic [3:0] fields;
  logic       errFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fields   <= '0;
      errFlag  <= 1'b0;
      eraseRow <= '0;
    end else begin
      if (strobe.ctrlWr) fields <= busData[3:0];
      if (strobe.errSet) errFlag <= 1'b1;
      else if (strobe.ctrlWr && busData[BIT_ERR]) errFlag <= 1'b0;
      if (strobe.eraseGo) eraseRow <= tablePtr[PTR_W-1:OFS_W];
    end
  end

  always_comb begin
    ctrlView = '0;
    ctrlView[3:0]     = fields;
    ctrlView[BIT_START] = busy;
    ctrlView[BIT_ERR]   = errFlag;
  end

  assert_row_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(eraseRow));
  assert_err_cleared_by_one_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(errFlag) && !errFlag) |-> $past(strobe.ctrlWr && busData[BIT_ERR]));
  assert_fields_frozen_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(fields));
endmodule

// File: rtl/flash_row_eraser.sv
module flash_row_eraser
  import flash_erase_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int PTR_W        = 22,
  parameter int ROW_BYTES    = 64,
  parameter int ERASE_CYCLES = 40,
  localparam int OFS_W       = $clog2(ROW_BYTES),
  localparam int ROW_W       = PTR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busSel,
  input  logic [DATA_W-1:0] busData,
  input  logic [PTR_W-1:0]  tablePtr,
  output logic [DATA_W-1:0] ctrlView,
  output logic              cpuStall,
  output logic              eraseReq,
  output logic [ROW_W-1:0]  eraseRow,
  input  logic              eraseAck
);
  eraseStrobe_t strobe;
  logic busy;

  flash_erase_ctrl #(.DATA_W(DATA_W), .ERASE_CYCLES(ERASE_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busSel(busSel), .busData(busData),
    .eraseAck(eraseAck), .strobe(strobe), .busy(busy), .eraseReq(eraseReq)
  );

  flash_erase_dp #(.DATA_W(DATA_W), .PTR_W(PTR_W), .OFS_W(OFS_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busData(busData),
    .tablePtr(tablePtr), .busy(busy), .ctrlView(ctrlView), .eraseRow(eraseRow)
  );

  assign cpuStall = busy;
endmodule

// File: tb/tb_flash_row_eraser.sv
module tb_flash_row_eraser;
  localparam int CLK_PERIOD = 10;
  localparam int ERASE = 40;

  logic clk = 1'b0, rstN = 1'b0, busWr = 1'b0, busSel = 1'b0, eraseAck = 1'b0;
  logic [7:0] busData = '0;
  logic [21:0] tablePtr = '0;
  logic [7:0] ctrlView;
  logic cpuStall, eraseReq;
  logic [15:0] eraseRow;

  flash_row_eraser #(.ERASE_CYCLES(ERASE)) dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busSel(busSel), .busData(busData),
    .tablePtr(tablePtr), .ctrlView(ctrlView), .cpuStall(cpuStall),
    .eraseReq(eraseReq), .eraseRow(eraseRow), .eraseAck(eraseAck)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, stallRun = 0, ackWait = 0;
  bit done = 0;

  // behavioural reference model
  logic [3:0] mFields;
  logic mErr, mReq;
  int mKey, mCnt;
  logic [15:0] mRow;

  always @(posedge clk) begin
    if (!rstN) begin
      mFields = 0; mErr = 0; mReq = 0; mKey = 0; mCnt = 0; mRow = 0;
    end else if (mCnt > 0) begin
      mCnt--;
      if (eraseAck || mCnt == 0) mReq = 0;
    end else if (busWr) begin
      if (busSel) begin
        if (mKey == 0 && busData == 8'h55) mKey = 1;
        else if (mKey == 1 && busData == 8'hAA) mKey = 2;
        else mKey = 0;
      end else begin
        mFields = busData[3:0];
        if (busData[5]) mErr = 0;
        if (busData[4]) begin
          if (!busData[2]) mErr = 1;
          else if (mKey == 2 && busData[0] && !busData[1] && busData[3]) begin
            mCnt = ERASE; mReq = 1; mRow = tablePtr[21:6];
          end
        end
        mKey = 0;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R2 ctrlView", 32'(ctrlView), 32'({2'b00, mErr, mCnt > 0, mFields}));
      chk("R7 cpuStall", 32'(cpuStall), 32'(mCnt > 0));
      chk("R8 eraseReq", 32'(eraseReq), 32'(mReq));
      if (mCnt > 0) chk("R9 eraseRow", 32'(eraseRow), 32'(mRow));
      if (cpuStall) stallRun++;
    end
  end

  // flash acknowledge: three cycles after a request is seen
  always @(negedge clk) begin
    eraseAck = 1'b0;
    if (eraseReq) begin
      ackWait++;
      if (ackWait == 3) begin eraseAck = 1'b1; ackWait = 0; end
    end else ackWait = 0;
  end

  task automatic wr(logic sel, logic [7:0] d);
    @(negedge clk);
    busWr = 1'b1; busSel = sel; busData = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic unlock();
    wr(1'b1, 8'h55);
    wr(1'b1, 8'hAA);
  endtask

  task automatic waitIdle();
    while (cpuStall) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset ctrlView", 32'(ctrlView), 0);
    chk("R1 reset stall", 32'(cpuStall), 0);
    chk("R1 reset req", 32'(eraseReq), 0);

    wr(1'b0, 8'h0D);
    chk("R2 fields readback", 32'(ctrlView), 32'h0D);

    wr(1'b0, 8'h1D);
    chk("R4 start unarmed", 32'(cpuStall), 0);
    chk("R4 start bit", 32'(ctrlView[4]), 0);

    tablePtr = 22'h12345 << 6 | 22'h3F;
    unlock();
    stallRun = 0;
    wr(1'b0, 8'h1D);
    chk("R3 stall after start", 32'(cpuStall), 1);
    chk("R8 req with stall", 32'(eraseReq), 1);
    chk("R9 row index", 32'(eraseRow), 32'h2345);
    tablePtr = 22'h3FFFFF;
    wr(1'b1, 8'h55);
    wr(1'b0, 8'h00);
    chk("R11 write ignored while busy", 32'(ctrlView[3:0]), 32'hD);
    chk("R8 row held", 32'(eraseRow), 32'h2345);
    chk("R8 req cleared by ack", 32'(eraseReq), 0);
    waitIdle();
    chk("R7 stall length", 32'(stallRun), ERASE);
    chk("R7 start self-clears", 32'(ctrlView[4]), 0);

    wr(1'b0, 8'h1D);
    chk("R6 unlock consumed", 32'(cpuStall), 0);

    wr(1'b1, 8'h55); wr(1'b1, 8'h00); wr(1'b1, 8'hAA);
    wr(1'b0, 8'h1D);
    chk("R5 wrong key", 32'(cpuStall), 0);
    wr(1'b1, 8'h55); wr(1'b0, 8'h0D); wr(1'b1, 8'hAA);
    wr(1'b0, 8'h1D);
    chk("R5 interleaved write", 32'(cpuStall), 0);

    unlock(); wr(1'b0, 8'h1F);
    chk("R12 cfg space", 32'({cpuStall, ctrlView[5]}), 0);
    unlock(); wr(1'b0, 8'h15);
    chk("R12 erase clear", 32'({cpuStall, ctrlView[5]}), 0);
    unlock(); wr(1'b0, 8'h1C);
    chk("R12 mem clear", 32'({cpuStall, ctrlView[5]}), 0);

    unlock(); wr(1'b0, 8'h19);
    chk("R10 error set", 32'(ctrlView[5]), 1);
    chk("R10 no erase", 32'(cpuStall), 0);
    wr(1'b0, 8'h00);
    chk("R10 error sticky", 32'(ctrlView[5]), 1);
    wr(1'b0, 8'h20);
    chk("R10 error cleared", 32'(ctrlView[5]), 0);

    tablePtr = 22'h00ABC0;
    unlock();
    stallRun = 0;
    wr(1'b0, 8'h1D);
    chk("R9 low bits ignored", 32'(eraseRow), 32'h02AF);
    waitIdle();
    chk("R7 second stall length", 32'(stallRun), ERASE);

    repeat (5) @(negedge clk);
    finishRun();
  end
endmodule